// File: doc/BRIEF.md
# Mailbox Event Interrupt Generator

This block raises interrupt requests for the mailbox of one function. It watches two event flags that the mailbox logic already keeps: a message waiting in the inbox, and a summary flag that is set while any acknowledgement for an outgoing message is outstanding. Software controls it through an enable bit and an 11-bit vector register. When the mailbox has a pending event and interrupts are enabled, the block emits a single-cycle request that carries the programmed vector. Delivering that request to the host is left to a downstream stage.

The block does not own the event flags, so they are set and cleared the same way whether interrupts are on or off. To learn the cause of a request, software reads the status separately. The expected service routine first disables the interrupt, then reads and clears the status, then enables the interrupt again. Each change of the enable bit from off to on re-arms the generator. If any event is still pending at that moment, a new request goes out at once. Events that arrive while the routine runs are therefore never lost. While the enable bit stays on, a request fires only once per burst of pending events.

Top module: `mbx_irq_gen`

## Requirements
- R1: After reset the enable bit reads 0, the vector register reads 0, and no request is driven (`irq_valid_o` = 0, `irq_vec_o` = 0).
- R2: A write to the vector register (`vec_wr_i` = 1) stores `vec_wdata_i` at the next clock edge. The stored 11-bit value is shown on `vec_rd_o`.
- R3: A control write (`ctl_wr_i` = 1) loads `ctl_wdata_i` into the enable bit at the next edge. The enable bit is shown on `int_en_o`, where 1 means enabled.
- R4: An event is pending when `msg_pend_i` or `ack_any_i` is 1. A request is a 1 on `irq_valid_o` that lasts exactly one clock cycle. It appears in the cycle after the edge at which the pending event was sampled with the generator enabled and armed.
- R5: `irq_vec_o` carries the vector register value held before the edge that forms the request. A vector write in that same cycle affects only later requests. When there is no request, `irq_vec_o` is 0.
- R6: While the block stays enabled and events stay pending, no more than one request is issued.
- R7: While the block is enabled, a sampled cycle with no pending event re-arms the generator. The next pending event then produces a new request.
- R8: While the block is disabled, no request is issued, whatever the event inputs do.
- R9: A control write that changes the enable bit from 0 to 1 re-arms the generator. If an event is pending one cycle after the write, the request appears in the following cycle.
- R10: Writing 1 while the block is already enabled does not re-arm it.
- R11: A control write of 0 in the same cycle that would otherwise form a request suppresses that request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released synchronously inside |
| msg_pend_i | input | 1 | Incoming message pending flag |
| ack_any_i | input | 1 | Summary flag for outstanding acknowledgements |
| ctl_wr_i | input | 1 | Write strobe for the enable bit |
| ctl_wdata_i | input | 1 | New enable value |
| vec_wr_i | input | 1 | Write strobe for the vector register |
| vec_wdata_i | input | 11 | New vector value |
| int_en_o | output | 1 | Current enable bit |
| vec_rd_o | output | 11 | Current vector register value |
| irq_valid_o | output | 1 | One-cycle interrupt request |
| irq_vec_o | output | 11 | Vector carried by the request |

## Verification
Two pairs of operations can land in the same cycle. The first pair is a vector write and request formation: the bench rewrites the vector in the very cycle a new event meets an armed generator, and it expects the request to carry the old vector while `vec_rd_o` shows the new one. The second pair is a disable write and request formation: the bench clears the events for one cycle to re-arm the generator, then raises a message together with a write of 0. It expects no request, and it expects a fresh request once the block is enabled again. A behavioural model, stepped on every edge, judges every output in every cycle.

// File: rtl/mbx_irq_pkg.sv
package mbx_irq_pkg;
  localparam int unsigned VEC_W_DEF = 11;

  typedef struct packed {
    logic msg;
    logic ack;
  } mbx_evt_t;
endpackage

// File: rtl/mbx_irq_vec.sv
module mbx_irq_vec #(
  parameter int unsigned VEC_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  logic [VEC_W-1:0] wdata_i,
  output logic [VEC_W-1:0] vec_o
);
  logic [VEC_W-1:0] vec_q, vec_d;

  always_comb begin
    vec_d = vec_q;
    if (wr_i) vec_d = wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vec_q <= '0;
    else        vec_q <= vec_d;
  end

  assign vec_o = vec_q;

  assert_vec_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> (vec_o == $past(wdata_i)));
  assert_vec_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_i |=> $stable(vec_o));
endmodule

// File: rtl/mbx_irq_ctl.sv
module mbx_irq_ctl
  import mbx_irq_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  mbx_evt_t evt_i,
  input  logic     wr_i,
  input  logic     wdata_i,
  output logic     en_o,
  output logic     fire_o
);
  logic en_q, en_d;
  logic arm_q, arm_d;
  logic pend, dis_wr, en_rise;

  assign pend    = evt_i.msg | evt_i.ack;
  assign dis_wr  = wr_i & ~wdata_i;
  assign en_rise = wr_i & wdata_i & ~en_q;

  always_comb begin
    fire_o = en_q & arm_q & pend & ~dis_wr;
    en_d   = en_q;
    if (wr_i) en_d = wdata_i;
    arm_d = arm_q;
    if (en_rise)              arm_d = 1'b1;
    else if (dis_wr | fire_o) arm_d = 1'b0;
    else if (en_q & ~pend)    arm_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      arm_q <= 1'b0;
    end else begin
      en_q  <= en_d;
      arm_q <= arm_d;
    end
  end

  assign en_o = en_q;

  assert_no_fire_disabled_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !en_o |-> !fire_o);
  assert_rearm_fire_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(en_o) && pend && !dis_wr) |-> fire_o);
  assert_fire_spaced_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_o && !wr_i) |=> !fire_o);
  assert_enable_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> (en_o == $past(wdata_i)));
endmodule

// File: rtl/mbx_irq_gen.sv
module mbx_irq_gen
  import mbx_irq_pkg::*;
#(
  parameter int unsigned VEC_W = VEC_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             msg_pend_i,
  input  logic             ack_any_i,
  input  logic             ctl_wr_i,
  input  logic             ctl_wdata_i,
  input  logic             vec_wr_i,
  input  logic [VEC_W-1:0] vec_wdata_i,
  output logic             int_en_o,
  output logic [VEC_W-1:0] vec_rd_o,
  output logic             irq_valid_o,
  output logic [VEC_W-1:0] irq_vec_o
);
  logic [1:0]       rst_sync_q;
  logic             rst_n_s;
  mbx_evt_t         evt;
  logic             fire;
  logic [VEC_W-1:0] vec;
  logic             irq_d;
  logic [VEC_W-1:0] irq_vec_d;
  logic             irq_q;
  logic [VEC_W-1:0] irq_vec_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  assign evt.msg = msg_pend_i;
  assign evt.ack = ack_any_i;

  mbx_irq_ctl u_ctl (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .evt_i   (evt),
    .wr_i    (ctl_wr_i),
    .wdata_i (ctl_wdata_i),
    .en_o    (int_en_o),
    .fire_o  (fire)
  );

  mbx_irq_vec #(.VEC_W(VEC_W)) u_vec (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .wr_i    (vec_wr_i),
    .wdata_i (vec_wdata_i),
    .vec_o   (vec)
  );

  always_comb begin
    irq_d     = fire;
    irq_vec_d = fire ? vec : '0;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      irq_q     <= 1'b0;
      irq_vec_q <= '0;
    end else begin
      irq_q     <= irq_d;
      irq_vec_q <= irq_vec_d;
    end
  end

  assign vec_rd_o    = vec;
  assign irq_valid_o = irq_q;
  assign irq_vec_o   = irq_vec_q;

  assert_pulse_one_cycle_R4: assert property (@(posedge clk) disable iff (!rst_n_s)
    irq_valid_o |=> !irq_valid_o);
  assert_irq_needs_event_R4: assert property (@(posedge clk) disable iff (!rst_n_s)
    irq_valid_o |-> $past(int_en_o && (msg_pend_i || ack_any_i)));
  assert_irq_old_vector_R5: assert property (@(posedge clk) disable iff (!rst_n_s)
    irq_valid_o |-> (irq_vec_o == $past(vec_rd_o)));
  assert_disable_wins_R11: assert property (@(posedge clk) disable iff (!rst_n_s)
    (ctl_wr_i && !ctl_wdata_i) |=> !irq_valid_o);
endmodule

// File: tb/sim_mbx_irq_gen.sv
`timescale 1ns/1ps
module sim_mbx_irq_gen;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        msg, ack, cw, cd, vw;
  logic [10:0] vd;
  logic        en_o, irq_o;
  logic [10:0] vec_o, ivec_o;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  bit       m_en = 0, m_arm = 0, m_irq = 0;
  int       m_vec = 0, m_ivec = 0;

  always #2.5 clk = ~clk;

  mbx_irq_gen u0 (
    .clk(clk), .rst_n(rst_n), .msg_pend_i(msg), .ack_any_i(ack),
    .ctl_wr_i(cw), .ctl_wdata_i(cd), .vec_wr_i(vw), .vec_wdata_i(vd),
    .int_en_o(en_o), .vec_rd_o(vec_o), .irq_valid_o(irq_o), .irq_vec_o(ivec_o)
  );

  // behavioural reference, stepped on each edge
  always @(posedge clk) begin
    cycles++;
    if (rst_n) begin
      bit pend, off, on, go;
      pend = msg | ack;
      off  = cw & ~cd;
      on   = cw & cd & ~m_en;
      go   = m_en & m_arm & pend & ~off;
      m_irq  = go;
      m_ivec = go ? m_vec : 0;
      if (on)              m_arm = 1;
      else if (off || go)  m_arm = 0;
      else if (m_en && !pend) m_arm = 1;
      if (cw) m_en = cd;
      if (vw) m_vec = vd;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    chk("R4 model irq_valid", irq_o, m_irq);
    chk("R5 model irq_vec", ivec_o, m_ivec);
    chk("R3 model int_en", en_o, m_en);
    chk("R2 model vec_rd", vec_o, m_vec);
    cw = 0; vw = 0;
  endtask

  initial begin
    rst_n = 0; msg = 0; ack = 0; cw = 0; cd = 0; vw = 0; vd = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) tick();
    chk("R1 reset en", en_o, 0);
    chk("R1 reset vec", vec_o, 0);
    chk("R1 reset irq", irq_o, 0);

    vw = 1; vd = 11'h5A3; tick();
    chk("R2 vector write", vec_o, 11'h5A3);
    vw = 1; vd = 11'h7FF; tick();
    chk("R2 vector all ones", vec_o, 11'h7FF);

    msg = 1; tick(); chk("R8 disabled no irq", irq_o, 0);
    ack = 1; tick(); chk("R8 disabled no irq", irq_o, 0);
    ack = 0; tick();

    cw = 1; cd = 1; tick();
    chk("R3 enable read", en_o, 1);
    chk("R9 not yet", irq_o, 0);
    tick();
    chk("R9 enable with pending fires", irq_o, 1);
    chk("R5 vector carried", ivec_o, 11'h7FF);
    tick(); chk("R4 pulse one cycle", irq_o, 0);
    repeat (3) begin tick(); chk("R6 single request", irq_o, 0); end

    cw = 1; cd = 1; tick(); chk("R10 no rearm", irq_o, 0);
    tick(); chk("R10 no rearm", irq_o, 0);

    msg = 0; tick();
    ack = 1; tick(); chk("R7 new event fires", irq_o, 1);
    tick(); chk("R6 quiet after", irq_o, 0);

    ack = 0; tick();
    msg = 1; vw = 1; vd = 11'h123; tick();
    chk("R5 collision irq", irq_o, 1);
    chk("R5 collision old vector", ivec_o, 11'h7FF);
    chk("R2 collision new value", vec_o, 11'h123);

    msg = 0; tick();
    msg = 1; cw = 1; cd = 0; tick();
    chk("R11 disable wins", irq_o, 0);
    chk("R3 disabled read", en_o, 0);
    tick(); chk("R8 stays quiet", irq_o, 0);

    cw = 1; cd = 1; tick(); tick();
    chk("R9 re-enable fires", irq_o, 1);
    chk("R5 new vector", ivec_o, 11'h123);
    msg = 0; repeat (3) tick();

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    wait (cycles > 5000);
    checks++; fails++;
    $display("FAIL watchdog actual=%0d expected<5000", cycles);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule